// File: doc/BRIEF.md
# Dual-Mode Host Port Decoder

This block sits between a host bus and the register file of an FM synthesis chip. The host sees four byte-wide port offsets. What each offset does depends on the register mode the chip is in. In the legacy mode, the address space is split into two banks of 256 registers. The host selects a bank and a register through one of two address offsets, then writes data through a data offset. In the native mode, the address space is a flat 11-bit range. The host loads the address one byte at a time and then writes or reads through a single data offset.

The block keeps an address latch and a mode flag. Each host write can turn into a one-cycle register-write request to the register file. That request carries the address, the data and the mode it was issued in. A native-mode read at the data offset raises a read request and passes the returned byte through to the host. Status reads pass an external status byte through. The chip enters native mode through a specific legacy-mode register write, and it leaves native mode through a write to the first offset.

Top module: `host_port_decoder`

## Requirements
- R1: After reset, native_o, newmode_o, reg_wr_o and addr_o are all 0.
- R2: In legacy mode, a write at offset 0 sets addr_o to the data byte with bits 10:8 cleared, which selects bank 0.
- R3: In legacy mode, a write at offset 2 sets addr_o to the data byte with bit 8 set and bits 10:9 cleared, which selects bank 1.
- R4: In legacy mode, a write at offset 1 or 3 raises reg_wr_o for exactly one cycle, starting on the edge after the strobe. reg_wr_addr_o equals addr_o, reg_wr_data_o equals the byte, and reg_wr_native_o is 0. The latch is left unchanged.
- R5: A legacy-mode register write at address 0x105 copies data bit 0 into newmode_o. If data bit 7 is set, native_o goes to 1. A write to that address with bit 7 clear leaves native_o at 0.
- R6: In native mode, a write at offset 0 clears native_o and loads addr_o with the byte, with bits 10:8 cleared.
- R7: In native mode, a write at offset 1 raises a one-cycle register-write request at addr_o with reg_wr_native_o = 1.
- R8: In native mode, a write at offset 2 replaces addr_o[7:0]. A write at offset 3 replaces addr_o[10:8] with data bits 2:0, so the address stays within 11 bits.
- R9: While rd_en_i is high, rdata_o depends on the offset. Offset 0 returns status_i. Offsets 2 and 3 return 0xFF. Offset 1 returns rd_back_i in native mode, with reg_rd_o = 1 and reg_rd_addr_o = addr_o. In legacy mode, offset 1 returns 0 with reg_rd_o = 0.
- R10: A mode change takes effect on the clock edge after the write that causes it. The next access is then decoded in the new mode. Native-mode register writes never change native_o or newmode_o, even at address 0x105.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 2 | Host port offset |
| wr_en_i | input | 1 | Host write strobe, one cycle per access |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write byte |
| status_i | input | 8 | Status byte returned at offset 0 |
| rd_back_i | input | 8 | Register readback byte from the register file |
| rdata_o | output | 8 | Host read byte, valid while rd_en_i is high |
| reg_rd_o | output | 1 | Native register read request |
| reg_rd_addr_o | output | 11 | Native register read address |
| reg_wr_o | output | 1 | Register write request pulse |
| reg_wr_addr_o | output | 11 | Register write address |
| reg_wr_data_o | output | 8 | Register write data |
| reg_wr_native_o | output | 1 | Mode the write request was issued in (1 = native) |
| addr_o | output | 11 | Current address latch |
| native_o | output | 1 | Native mode flag |
| newmode_o | output | 1 | Extended-mode flag captured from register 0x105 |

## Verification
In legacy mode the bench writes to both address offsets and both data offsets. This tells the bank-0 load apart from the bank-1 load, and shows that offset 3 acts as a data port rather than an address port. It writes to register 0x105 twice: once with bit 7 clear, to isolate the new-mode flag, and once with bit 7 set, to enter native mode. The very next access is a write at offset 3, which would be a register write in legacy mode but loads the high address byte in native mode. A native write to 0x105 checks that native data writes leave both flags alone. A high-byte value of 0xFF checks the 11-bit mask. Reads at every offset in both modes tell status, readback, zero and all-ones apart.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 11;

  typedef enum logic [1:0] {
    OFF_ADDR_LO  = 2'd0,
    OFF_DATA     = 2'd1,
    OFF_ADDR_HI  = 2'd2,
    OFF_DATA_ALT = 2'd3
  } port_off_e;

  // Legacy-mode register that carries the mode-switch bits
  localparam logic [ADDR_W-1:0] MODE_REG_ADDR = 11'h105;
  localparam int NATIVE_BIT  = 7;
  localparam int NEWMODE_BIT = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              native;
  } wr_req_t;
endpackage

// File: rtl/hpd_addr_latch.sv
module hpd_addr_latch
  import hpd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic          native_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o
);
  localparam int HI_W = AW - DW;

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_i) begin
      unique case (sel_i)
        OFF_ADDR_LO: addr_d = {{HI_W{1'b0}}, data_i};
        OFF_ADDR_HI: begin
          if (native_i) addr_d[DW-1:0] = data_i;
          else          addr_d = {{(HI_W-1){1'b0}}, 1'b1, data_i};
        end
        OFF_DATA_ALT: begin
          if (native_i) addr_d[AW-1:DW] = data_i[HI_W-1:0];
        end
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/hpd_mode_ctrl.sv
module hpd_mode_ctrl
  import hpd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          native_o,
  output logic          newmode_o
);
  logic native_q, newmode_q;
  logic legacy_data_wr, hit_mode_reg, leave_native;

  assign legacy_data_wr = wr_i && !native_q && sel_i[0];
  assign hit_mode_reg   = legacy_data_wr && (addr_i == MODE_REG_ADDR);
  assign leave_native   = wr_i && native_q && (sel_i == OFF_ADDR_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      native_q  <= 1'b0;
      newmode_q <= 1'b0;
    end else begin
      if (hit_mode_reg) begin
        newmode_q <= data_i[NEWMODE_BIT];
        if (data_i[NATIVE_BIT]) native_q <= 1'b1;
      end else if (leave_native) begin
        native_q <= 1'b0;
      end
    end
  end

  assign native_o  = native_q;
  assign newmode_o = newmode_q;
endmodule

// File: rtl/hpd_wr_issue.sv
module hpd_wr_issue
  import hpd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic          native_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          req_vld_o,
  output wr_req_t       req_o
);
  logic    fire;
  wr_req_t req_q;
  logic    vld_q;

  // legacy: both odd offsets are data ports; native: only offset 1
  assign fire = wr_i && (native_i ? (sel_i == OFF_DATA) : sel_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      req_q <= '0;
    end else begin
      vld_q <= fire;
      if (fire) req_q <= '{addr: addr_i, data: data_i, native: native_i};
    end
  end

  assign req_vld_o = vld_q;
  assign req_o     = req_q;
endmodule

// File: rtl/hpd_rd_mux.sv
module hpd_rd_mux
  import hpd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          rd_i,
  input  logic [1:0]    sel_i,
  input  logic          native_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rd_back_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [DW-1:0] mux;

  always_comb begin
    unique case (sel_i)
      OFF_ADDR_LO: mux = status_i;
      OFF_DATA:    mux = native_i ? rd_back_i : '0;
      default:     mux = '1;
    endcase
  end

  assign rdata_o   = rd_i ? mux : '0;
  assign rd_req_o  = rd_i && native_i && (sel_i == OFF_DATA);
  assign rd_addr_o = addr_i;
endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder
  import hpd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        port_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rd_back_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_rd_addr_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_wr_addr_o,
  output logic [DATA_W-1:0] reg_wr_data_o,
  output logic              reg_wr_native_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              native_o,
  output logic              newmode_o
);
  logic [ADDR_W-1:0] latch;
  logic              native;
  wr_req_t           req;

  hpd_addr_latch i_latch (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .sel_i(port_sel_i), .native_i(native),
    .data_i(wdata_i), .addr_o(latch)
  );

  hpd_mode_ctrl i_mode (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .sel_i(port_sel_i), .addr_i(latch),
    .data_i(wdata_i), .native_o(native), .newmode_o(newmode_o)
  );

  hpd_wr_issue i_wr (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .sel_i(port_sel_i), .native_i(native),
    .addr_i(latch), .data_i(wdata_i),
    .req_vld_o(reg_wr_o), .req_o(req)
  );

  hpd_rd_mux i_rd (
    .rd_i(rd_en_i), .sel_i(port_sel_i), .native_i(native),
    .addr_i(latch), .status_i(status_i), .rd_back_i(rd_back_i),
    .rdata_o(rdata_o), .rd_req_o(reg_rd_o), .rd_addr_o(reg_rd_addr_o)
  );

  assign reg_wr_addr_o   = req.addr;
  assign reg_wr_data_o   = req.data;
  assign reg_wr_native_o = req.native;
  assign addr_o          = latch;
  assign native_o        = native;
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  port_sel_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        reg_rd_o,
  input logic        reg_wr_o,
  input logic [10:0] reg_wr_addr_o,
  input logic [10:0] addr_o,
  input logic        native_o
);
  p_wr_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(wr_en_i) &&
      ($past(native_o) ? ($past(port_sel_i) == 2'd1) : $past(port_sel_i[0])));

  p_wr_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> reg_wr_addr_o == $past(addr_o));

  p_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(native_o) |-> $past(wr_en_i) && $past(port_sel_i[0]) &&
      ($past(addr_o) == 11'h105) && $past(wdata_i[7]));

  p_leave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    native_o && wr_en_i && port_sel_i == 2'd0 |=> !native_o);

  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(addr_o));

  p_legacy_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !native_o |-> addr_o[10:9] == 2'b00);

  p_rd_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && port_sel_i[1] |-> rdata_o == 8'hFF);

  p_rd_legacy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !native_o && port_sel_i == 2'd1 |-> rdata_o == 8'h00 && !reg_rd_o);
endmodule

bind host_port_decoder hpd_checker i_hpd_checker (
  .clk_i, .rst_ni, .port_sel_i, .wr_en_i, .rd_en_i, .wdata_i,
  .rdata_o, .reg_rd_o, .reg_wr_o, .reg_wr_addr_o, .addr_o, .native_o
);

// File: tb/test_host_port_decoder.sv
module test_host_port_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  port_sel_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  wdata_i = '0, status_i = 8'hA5;
  logic [7:0]  rd_back_i, rdata_o, reg_wr_data_o;
  logic        reg_rd_o, reg_wr_o, reg_wr_native_o, native_o, newmode_o;
  logic [10:0] reg_rd_addr_o, reg_wr_addr_o, addr_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [10:0] m_latch = '0;
  logic        m_native = 1'b0;
  logic        m_newmode = 1'b0;
  logic [19:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign rd_back_i = reg_rd_addr_o[7:0] ^ 8'h3C;

  host_port_decoder i_host_port_decoder (.*);

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Host write; bench model follows the requirements, not the RTL
  task automatic do_wr(logic [1:0] off, logic [7:0] d);
    @(negedge clk_i);
    port_sel_i = off; wdata_i = d; wr_en_i = 1'b1;
    if (!m_native) begin
      case (off)
        2'd0: m_latch = {3'b000, d};
        2'd2: m_latch = {3'b001, d};
        default: begin
          exp_q.push_back({m_latch, d, 1'b0});
          if (m_latch == 11'h105) begin
            m_newmode = d[0];
            if (d[7]) m_native = 1'b1;
          end
        end
      endcase
    end else begin
      case (off)
        2'd0: begin m_latch = {3'b000, d}; m_native = 1'b0; end
        2'd1: exp_q.push_back({m_latch, d, 1'b1});
        2'd2: m_latch[7:0] = d;
        default: m_latch[10:8] = d[2:0];
      endcase
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk_state(string req);
    chk({req, " addr"}, 20'(addr_o), 20'(m_latch));
    chk({req, " mode"}, 20'(native_o), 20'(m_native));
    chk({req, " newmode"}, 20'(newmode_o), 20'(m_newmode));
  endtask

  task automatic do_rd(string req, logic [1:0] off, logic [7:0] exp, logic exp_req);
    @(negedge clk_i);
    port_sel_i = off; rd_en_i = 1'b1;
    #1;
    chk({req, " rdata"}, 20'(rdata_o), 20'(exp));
    chk({req, " rd_req"}, 20'(reg_rd_o), 20'(exp_req));
    if (exp_req) chk({req, " rd_addr"}, 20'(reg_rd_addr_o), 20'(m_latch));
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // Monitor: pops expected write requests (R4, R7)
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && reg_wr_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R7 unexpected write actual %0h expected none",
                 {reg_wr_addr_o, reg_wr_data_o, reg_wr_native_o});
      end else begin
        chk("R4_R7 write request", {reg_wr_addr_o, reg_wr_data_o, reg_wr_native_o},
            exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 addr", 20'(addr_o), 20'h0);
    chk("R1 mode", 20'(native_o), 20'h0);
    chk("R1 newmode", 20'(newmode_o), 20'h0);
    chk("R1 wr", 20'(reg_wr_o), 20'h0);
    rst_ni = 1'b1;

    do_wr(2'd0, 8'h40); chk_state("R2");
    chk("R2 bank0", 20'(addr_o), 20'h040);
    do_wr(2'd1, 8'h11); chk_state("R4 off1");
    do_wr(2'd2, 8'h20); chk("R3 bank1", 20'(addr_o), 20'h120);
    do_wr(2'd3, 8'h22); chk_state("R4 off3");

    do_rd("R9 status", 2'd0, 8'hA5, 1'b0);
    do_rd("R9 legacy data", 2'd1, 8'h00, 1'b0);
    do_rd("R9 off2", 2'd2, 8'hFF, 1'b0);
    do_rd("R9 off3", 2'd3, 8'hFF, 1'b0);

    do_wr(2'd2, 8'h05);
    do_wr(2'd1, 8'h01);
    chk("R5 newmode set", 20'(newmode_o), 20'h1);
    chk("R5 no native", 20'(native_o), 20'h0);
    do_wr(2'd3, 8'h80);
    chk("R5 native", 20'(native_o), 20'h1);
    chk("R5 newmode clr", 20'(newmode_o), 20'h0);

    do_wr(2'd3, 8'h06);
    chk("R10 next access native", 20'(addr_o), 20'h605);
    do_wr(2'd2, 8'h34); chk("R8 low", 20'(addr_o), 20'h634);
    do_wr(2'd3, 8'hFF); chk("R8 mask", 20'(addr_o), 20'h734);
    do_wr(2'd1, 8'h99); chk_state("R7");

    do_wr(2'd3, 8'h01); do_wr(2'd2, 8'h05);
    do_wr(2'd1, 8'h01);
    chk("R10 native stays", 20'(native_o), 20'h1);
    chk("R10 newmode stays", 20'(newmode_o), 20'h0);

    status_i = 8'h60;
    do_rd("R9 native data", 2'd1, 8'h05 ^ 8'h3C, 1'b1);
    do_rd("R9 native status", 2'd0, 8'h60, 1'b0);

    do_wr(2'd0, 8'h77);
    chk("R6 mode", 20'(native_o), 20'h0);
    chk("R6 addr", 20'(addr_o), 20'h077);
    do_wr(2'd1, 8'h42); chk_state("R6 legacy again");

    repeat (3) @(negedge clk_i);
    chk("R4 queue drained", 20'(exp_q.size()), 20'h0);
    finish_run();
  end
endmodule